// File: doc/BRIEF.md
# Register-Mapped Buffered UART

This block is a byte-wide serial port for a small processor bus. Software sees two locations, picked by a single register-select input. At select 0 a write goes to the control register and a read returns the status byte. At select 1 a write hands a byte to the transmitter and a read pops the oldest received byte. The bus strobes are active low. Each access takes effect once, in the first clock cycle the strobe is low.

Frames are fixed at 8 data bits, no parity and one stop bit, with the least significant bit sent first. All bit timing comes from a single-cycle enable input that pulses sixteen times per bit period. The receiver and the transmitter share that enable. Received bytes go into a small FIFO. The active-low ready-to-send output throttles the far end when the FIFO is close to full. An interrupt output combines a receive condition and a transmit condition.

Top module: `uart_regport`

## Requirements
- R1: When select is 0, a write updates the control register and a read returns the status byte. When select is 1, a write offers a byte to the transmitter and a read returns the FIFO head, or 0x00 when the FIFO is empty.
- R2: The status byte is laid out as follows. Bit 0 is 1 when the receive FIFO is not empty. Bit 1 is 1 when the transmit holding register is empty. Bit 7 equals the interrupt output. Bits 2 and 3 (carrier detect and clear to send) and bits 4 to 6 always read 0.
- R3: `txd` idles high. A frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts 16 enable pulses.
- R4: A data write is accepted only while the holding register is empty, and it then clears status bit 1. A data write while the holding register is full is ignored. The holding register empties when the shifter takes the byte on an enable pulse.
- R5: While `ctsN` is high, no new frame starts. The held byte waits until `ctsN` is low.
- R6: The receiver acts on a high-to-low transition seen on enable pulses. It confirms the start bit low at the 8th enable after detection. It then samples the 8 data bits and the stop bit 16 enables apart. A byte whose stop bit samples low is discarded.
- R7: The receive FIFO holds 16 bytes in arrival order. A data read pops one entry. A read of an empty FIFO changes nothing. A byte that arrives while the FIFO is full is dropped.
- R8: `rtsN` is high when control bits 6:5 are 10, and low for the codes 00, 01 and 11. `rtsN` is also forced high while the FIFO holds 14 or more bytes.
- R9: `irq` is 1 when (control bit 7 is 1 and the FIFO is not empty) or (control bits 6:5 are 01 and the holding register is empty).
- R10: A control write with bits 1:0 equal to 11 empties the FIFO, drops any held or in-flight transmit byte and returns `txd` high. It leaves the earlier control fields unchanged.
- R11: Transmit and receive state advance only on cycles where `bitTickEn` is 1.
- R12: A strobe held low for several cycles performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| regSel | input | 1 | 0 = control/status, 1 = data |
| dataIn | input | 8 | Write data from the bus |
| dataOut | output | 8 | Read data to the bus |
| bitTickEn | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| ctsN | input | 1 | Active-low clear to send from the far end |
| rtsN | output | 1 | Active-low ready to send to the far end |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check these properties on every cycle:
- The FIFO occupancy never goes past its depth.
- A pop never reaches an empty FIFO.
- A transmit byte is only loaded into an empty holding register.
- `txd` stays put on cycles with no enable and no master reset.
- An idle transmitter stays idle while `ctsN` is high.
- A master reset always leaves the line high with both buffers empty.

Some behaviour only the bench scenarios can show:
- The serial bit order and the 16-enable bit length.
- Start confirmation and stop-bit rejection on the receive side.
- The order in which the FIFO returns bytes, and the dropping of a 17th byte.
- The ready-to-send threshold.
- That the control fields survive a master reset.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int OVERSAMPLE = 16;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int TICK_W     = $clog2(OVERSAMPLE);
  localparam int FBIT_W     = $clog2(FRAME_BITS);
  localparam int DBIT_W     = $clog2(DATA_BITS);

  localparam logic [1:0] CODE_MRESET   = 2'b11;
  localparam logic [1:0] TC_TXINT_ON   = 2'b01;
  localparam logic [1:0] TC_RTS_HIGH   = 2'b10;

  // one-cycle commands from the register front end to the datapath
  typedef struct packed {
    logic txLoad;
    logic rxPop;
    logic masterClr;
  } serStrobes_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        regSel,
  input  logic [4:0]  ctlField,   // {bit7, bit6, bit5, bit1, bit0} of the bus byte
  input  logic        tdre,
  input  logic        rdrf,
  input  logic        nearFull,
  input  logic [7:0]  rxHead,
  output serStrobes_t strobes,
  output logic [7:0]  dataOut,
  output logic        rtsN,
  output logic        irq
);

  logic       wrPrevN, rdPrevN;
  logic       wrAct, rdAct, ctlWrite, isMasterReset;
  logic [1:0] txCtl;
  logic       rxIntEn;
  logic       txIntEn;
  logic [7:0] statusByte;

  // first low cycle of each strobe is the access cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrevN <= 1'b1;
      rdPrevN <= 1'b1;
    end else begin
      wrPrevN <= wrN;
      rdPrevN <= rdN;
    end
  end

  assign wrAct         = !wrN && wrPrevN;
  assign rdAct         = !rdN && rdPrevN;
  assign ctlWrite      = wrAct && !regSel;
  assign isMasterReset = (ctlField[1:0] == CODE_MRESET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCtl   <= 2'b00;
      rxIntEn <= 1'b0;
    end else if (ctlWrite && !isMasterReset) begin
      txCtl   <= ctlField[3:2];
      rxIntEn <= ctlField[4];
    end
  end

  always_comb begin
    strobes.masterClr = ctlWrite && isMasterReset;
    strobes.txLoad    = wrAct && regSel && tdre;
    strobes.rxPop     = rdAct && regSel && rdrf;
  end

  assign txIntEn    = (txCtl == TC_TXINT_ON);
  assign irq        = (rxIntEn && rdrf) || (txIntEn && tdre);
  assign rtsN       = (txCtl == TC_RTS_HIGH) || nearFull;
  // carrier detect (bit 2) and clear to send (bit 3) are tied to 0
  assign statusByte = {irq, 3'b000, 1'b0, 1'b0, tdre, rdrf};
  assign dataOut    = regSel ? rxHead : statusByte;

endmodule

// File: rtl/serport_datapath.sv
module serport_datapath
  import serport_pkg::*;
#(
  parameter int FIFO_DEPTH      = 16,
  parameter int NEAR_FULL_LEVEL = FIFO_DEPTH - 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTickEn,
  input  logic        rxd,
  input  logic        ctsN,
  input  logic [7:0]  txByte,
  input  serStrobes_t strobes,
  output logic        txd,
  output logic        tdre,
  output logic        rdrf,
  output logic        nearFull,
  output logic [7:0]  rxHead
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [TICK_W-1:0] TICK_LAST  = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] TICK_MID   = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [FBIT_W-1:0] FBIT_LAST  = FBIT_W'(FRAME_BITS - 1);
  localparam logic [DBIT_W-1:0] DBIT_LAST  = DBIT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0]  CNT_FULL   = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0]  CNT_NEAR   = CNT_W'(NEAR_FULL_LEVEL);
  localparam logic [PTR_W-1:0]  PTR_LAST   = PTR_W'(FIFO_DEPTH - 1);

  // ---------------- transmitter ----------------
  logic [DATA_BITS-1:0]  holdReg;
  logic                  holdFull;
  logic [FRAME_BITS-1:0] txShift;
  logic                  txBusy;
  logic [TICK_W-1:0]     txTickCnt;
  logic [FBIT_W-1:0]     txBitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdFull  <= 1'b0;
      txShift   <= '1;
      txBusy    <= 1'b0;
      txTickCnt <= '0;
      txBitCnt  <= '0;
    end else if (strobes.masterClr) begin
      holdFull  <= 1'b0;
      txShift   <= '1;
      txBusy    <= 1'b0;
      txTickCnt <= '0;
      txBitCnt  <= '0;
    end else begin
      if (strobes.txLoad) begin
        holdReg  <= txByte;
        holdFull <= 1'b1;
      end
      if (bitTickEn) begin
        if (!txBusy) begin
          if (holdFull && !ctsN) begin
            txShift   <= {1'b1, holdReg, 1'b0};
            txBusy    <= 1'b1;
            holdFull  <= 1'b0;
            txTickCnt <= '0;
            txBitCnt  <= '0;
          end
        end else if (txTickCnt == TICK_LAST) begin
          txTickCnt <= '0;
          txShift   <= {1'b1, txShift[FRAME_BITS-1:1]};
          if (txBitCnt == FBIT_LAST) txBusy <= 1'b0;
          else                       txBitCnt <= txBitCnt + 1'b1;
        end else begin
          txTickCnt <= txTickCnt + 1'b1;
        end
      end
    end
  end

  assign txd  = txShift[0];
  assign tdre = !holdFull;

  // ---------------- receiver ----------------
  logic                 rxMeta, rxSync, rxLastHigh;
  rxState_t             rxState;
  logic [TICK_W-1:0]    rxTickCnt;
  logic [DBIT_W-1:0]    rxBitIdx;
  logic [DATA_BITS-1:0] rxShift;
  logic                 rxPush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState    <= RX_IDLE;
      rxTickCnt  <= '0;
      rxBitIdx   <= '0;
      rxShift    <= '0;
      rxLastHigh <= 1'b1;
    end else if (strobes.masterClr) begin
      rxState    <= RX_IDLE;
      rxTickCnt  <= '0;
      rxBitIdx   <= '0;
    end else if (bitTickEn) begin
      unique case (rxState)
        RX_IDLE: begin
          rxLastHigh <= rxSync;
          if (rxLastHigh && !rxSync) begin
            rxState   <= RX_START;
            rxTickCnt <= '0;
          end
        end
        RX_START: begin
          if (rxTickCnt == TICK_MID) begin
            rxTickCnt <= '0;
            rxBitIdx  <= '0;
            rxState   <= rxSync ? RX_IDLE : RX_DATA;
          end else begin
            rxTickCnt <= rxTickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxTickCnt == TICK_LAST) begin
            rxTickCnt <= '0;
            rxShift   <= {rxSync, rxShift[DATA_BITS-1:1]};
            if (rxBitIdx == DBIT_LAST) rxState <= RX_STOP;
            else                       rxBitIdx <= rxBitIdx + 1'b1;
          end else begin
            rxTickCnt <= rxTickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (rxTickCnt == TICK_LAST) begin
            rxTickCnt  <= '0;
            rxLastHigh <= rxSync;
            rxState    <= RX_IDLE;
          end else begin
            rxTickCnt <= rxTickCnt + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxPush = bitTickEn && !strobes.masterClr && (rxState == RX_STOP)
                  && (rxTickCnt == TICK_LAST) && rxSync;

  // ---------------- receive FIFO ----------------
  logic [DATA_BITS-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     fifoCount;
  logic                 doPush, doPop;

  assign doPush = rxPush && (fifoCount != CNT_FULL);
  assign doPop  = strobes.rxPop && (fifoCount != '0);

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (strobes.masterClr) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fifoCount <= fifoCount + 1'b1;
      else if (doPop && !doPush) fifoCount <= fifoCount - 1'b1;
    end
  end

  assign rdrf     = (fifoCount != '0);
  assign nearFull = (fifoCount >= CNT_NEAR);
  assign rxHead   = rdrf ? fifoMem[rdPtr] : '0;

  // ---------------- checks ----------------
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_FULL)
    else $error("FIFO occupancy beyond depth");

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxPop |-> (fifoCount != '0))
    else $error("pop requested on empty FIFO");

  assert_load_only_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |-> !holdFull)
    else $error("transmit load into full holding register");

  assert_tick_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTickEn && !strobes.masterClr) |=> $stable(txd))
    else $error("txd moved without an enable pulse");

  assert_cts_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && ctsN) |=> !txBusy)
    else $error("frame started while clear-to-send inactive");

  assert_mreset_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.masterClr |=> (txd && !holdFull && (fifoCount == '0)))
    else $error("master reset left state behind");

endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import serport_pkg::*;
#(
  parameter int FIFO_DEPTH      = 16,
  parameter int NEAR_FULL_LEVEL = FIFO_DEPTH - 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       regSel,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  input  logic       bitTickEn,
  input  logic       rxd,
  output logic       txd,
  input  logic       ctsN,
  output logic       rtsN,
  output logic       irq
);

  serStrobes_t strobes;
  logic        tdre, rdrf, nearFull;
  logic [7:0]  rxHead;

  serport_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrN      (wrN),
    .rdN      (rdN),
    .regSel   (regSel),
    .ctlField ({dataIn[7:5], dataIn[1:0]}),
    .tdre     (tdre),
    .rdrf     (rdrf),
    .nearFull (nearFull),
    .rxHead   (rxHead),
    .strobes  (strobes),
    .dataOut  (dataOut),
    .rtsN     (rtsN),
    .irq      (irq)
  );

  serport_datapath #(
    .FIFO_DEPTH      (FIFO_DEPTH),
    .NEAR_FULL_LEVEL (NEAR_FULL_LEVEL)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .bitTickEn (bitTickEn),
    .rxd       (rxd),
    .ctsN      (ctsN),
    .txByte    (dataIn),
    .strobes   (strobes),
    .txd       (txd),
    .tdre      (tdre),
    .rdrf      (rdrf),
    .nearFull  (nearFull),
    .rxHead    (rxHead)
  );

endmodule

// File: tb/tb_uart_regport.sv
module tb_uart_regport;

  localparam int BIT_CLKS = 64;   // 16 enables, one every 4 clocks

  logic       clk = 1'b0;
  logic       rstN, wrN, rdN, regSel, bitTickEn, rxd, ctsN;
  logic [7:0] dataIn;
  logic       txd, rtsN, irq;
  logic [7:0] dataOut;

  always #10 clk = ~clk;

  uart_regport dut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .regSel(regSel),
    .dataIn(dataIn), .dataOut(dataOut), .bitTickEn(bitTickEn),
    .rxd(rxd), .txd(txd), .ctsN(ctsN), .rtsN(rtsN), .irq(irq)
  );

  int         nChecks = 0;
  int         nFails  = 0;
  int         txFrames = 0;
  bit         tickRun = 1'b0;
  int         tickPhase = 0;
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // enable generator: one pulse every 4 clocks while running
  initial begin
    bitTickEn = 1'b0;
    forever begin
      @(negedge clk);
      if (tickRun) begin
        tickPhase = (tickPhase + 1) % 4;
        bitTickEn = (tickPhase == 0);
      end else begin
        bitTickEn = 1'b0;
      end
    end
  end

  // transmit monitor: decode frames and compare with the scoreboard queue
  initial begin
    forever begin
      logic [7:0] got;
      @(negedge txd);
      txFrames++;
      repeat (BIT_CLKS / 2) @(negedge clk);
      check(txd == 1'b0, "R3 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT_CLKS) @(negedge clk);
        got[i] = txd;
      end
      repeat (BIT_CLKS) @(negedge clk);
      check(txd == 1'b1, "R3 stop bit", txd, 1);
      if (txExp.size() == 0) begin
        check(1'b0, "R3/R4 unexpected frame", got, 0);
      end else begin
        logic [7:0] e;
        e = txExp.pop_front();
        check(got == e, "R3 frame data", got, e);
      end
    end
  end

  task automatic busWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; dataIn = d; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
  endtask

  task automatic busRead(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; rdN = 1'b0;
    #1 d = dataOut;
    @(negedge clk);
    rdN = 1'b1;
  endtask

  task automatic sendRx(input logic [7:0] b, input bit stopHigh, input bit kept);
    if (kept) rxExp.push_back(b);
    @(negedge clk); rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stopHigh;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic drainRx(input string req);
    logic [7:0] d;
    while (rxExp.size() != 0) begin
      logic [7:0] e;
      e = rxExp.pop_front();
      busRead(1'b1, d);
      check(d == e, req, d, e);
    end
    busRead(1'b0, d);
    check(d[0] == 1'b0, {req, " empty after drain"}, d[0], 0);
  endtask

  task automatic waitTx();
    int guard = 0;
    while (txExp.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 20000, "R3 frames complete", guard, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int f0;
    rstN = 1'b0; wrN = 1'b1; rdN = 1'b1; regSel = 1'b0; dataIn = '0;
    rxd = 1'b1; ctsN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    tickRun = 1'b1;
    repeat (4) @(negedge clk);

    // reset state, R1 / R2
    busRead(1'b0, d);
    check(d == 8'h02, "R1/R2 reset status", d, 8'h02);
    check(txd == 1'b1, "R3 idle line", txd, 1);
    check(rtsN == 1'b0, "R8 reset rts", rtsN, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);

    // basic transmit, back-to-back
    txExp.push_back(8'hA5); busWrite(1'b1, 8'hA5);
    repeat (12) @(negedge clk);
    txExp.push_back(8'h3C); busWrite(1'b1, 8'h3C);
    waitTx();
    busRead(1'b0, d);
    check(d[1] == 1'b1, "R4 tdre after send", d[1], 1);

    // R4 write while full ignored, R11 no progress without enables
    tickRun = 1'b0;
    repeat (3) @(negedge clk);
    txExp.push_back(8'h11); busWrite(1'b1, 8'h11);
    busRead(1'b0, d);
    check(d[1] == 1'b0, "R4 tdre cleared", d[1], 0);
    busWrite(1'b1, 8'h22);
    f0 = txFrames;
    repeat (300) @(negedge clk);
    check(txd == 1'b1 && txFrames == f0, "R11 frozen without enable", txd, 1);
    tickRun = 1'b1;
    waitTx();
    repeat (800) @(negedge clk);
    check(txFrames == f0 + 1, "R4 second write dropped", txFrames - f0, 1);

    // R5 clear-to-send gating
    ctsN = 1'b1;
    f0 = txFrames;
    txExp.push_back(8'h5A); busWrite(1'b1, 8'h5A);
    repeat (1500) @(negedge clk);
    check(txFrames == f0, "R5 held by cts", txFrames - f0, 0);
    busRead(1'b0, d);
    check(d[1] == 1'b0, "R5 byte still held", d[1], 0);
    ctsN = 1'b0;
    waitTx();

    // R6 / R7 receive
    sendRx(8'h96, 1'b1, 1'b1);
    sendRx(8'h01, 1'b1, 1'b1);
    busRead(1'b0, d);
    check(d == 8'h03, "R2 status with data", d, 8'h03);
    drainRx("R7 receive order");

    // R6 low stop discarded
    sendRx(8'hFF, 1'b0, 1'b0);
    busRead(1'b0, d);
    check(d[0] == 1'b0, "R6 bad stop discarded", d[0], 0);
    sendRx(8'h42, 1'b1, 1'b1);
    drainRx("R6 receive after bad stop");

    // R9 interrupts
    busWrite(1'b0, 8'h80);
    check(irq == 1'b0, "R9 rx int, no data", irq, 0);
    sendRx(8'h77, 1'b1, 1'b1);
    check(irq == 1'b1, "R9 rx int with data", irq, 1);
    busRead(1'b0, d);
    check(d == 8'h83, "R2 irq in status", d, 8'h83);
    drainRx("R9 rx drain");
    check(irq == 1'b0, "R9 rx int cleared", irq, 0);
    busWrite(1'b0, 8'h20);
    check(irq == 1'b1, "R9 tx int empty", irq, 1);
    tickRun = 1'b0;
    repeat (3) @(negedge clk);
    txExp.push_back(8'hC3); busWrite(1'b1, 8'hC3);
    check(irq == 1'b0, "R9 tx int full", irq, 0);
    tickRun = 1'b1;
    waitTx();
    check(irq == 1'b1, "R9 tx int after send", irq, 1);
    busWrite(1'b0, 8'h00);

    // R8 rts control codes
    busWrite(1'b0, 8'h40);
    check(rtsN == 1'b1, "R8 code 10", rtsN, 1);
    busWrite(1'b0, 8'h60);
    check(rtsN == 1'b0, "R8 code 11", rtsN, 0);
    busWrite(1'b0, 8'h00);
    check(rtsN == 1'b0, "R8 code 00", rtsN, 0);

    // R10 master reset
    busWrite(1'b0, 8'h40);
    sendRx(8'h33, 1'b1, 1'b0);
    tickRun = 1'b0;
    repeat (3) @(negedge clk);
    busWrite(1'b1, 8'h44);
    busWrite(1'b0, 8'h03);
    busRead(1'b0, d);
    check(d == 8'h02, "R10 status after reset", d, 8'h02);
    check(txd == 1'b1, "R10 line idle", txd, 1);
    check(rtsN == 1'b1, "R10 control kept", rtsN, 1);
    busRead(1'b1, d);
    check(d == 8'h00, "R1 empty data read", d, 0);
    tickRun = 1'b1;
    f0 = txFrames;
    repeat (800) @(negedge clk);
    check(txFrames == f0, "R10 held byte dropped", txFrames - f0, 0);
    busWrite(1'b0, 8'h00);

    // R7 / R8 fill the FIFO
    for (int i = 0; i < 13; i++) sendRx(8'(8'h10 + i), 1'b1, 1'b1);
    check(rtsN == 1'b0, "R8 below threshold", rtsN, 0);
    sendRx(8'h1D, 1'b1, 1'b1);
    check(rtsN == 1'b1, "R8 near full", rtsN, 1);
    sendRx(8'h1E, 1'b1, 1'b1);
    sendRx(8'h1F, 1'b1, 1'b1);
    sendRx(8'hEE, 1'b1, 1'b0);
    drainRx("R7 full FIFO order");
    check(rtsN == 1'b0, "R8 released", rtsN, 0);
    busRead(1'b1, d);
    busRead(1'b0, d);
    check(d == 8'h02, "R7 empty pop harmless", d, 8'h02);

    // R12 long read strobe pops once
    sendRx(8'hAB, 1'b1, 1'b1);
    sendRx(8'hCD, 1'b1, 1'b1);
    @(negedge clk);
    regSel = 1'b1; rdN = 1'b0;
    #1 d = dataOut;
    check(d == 8'hAB, "R12 long read head", d, 8'hAB);
    void'(rxExp.pop_front());
    repeat (5) @(negedge clk);
    rdN = 1'b1;
    drainRx("R12 one pop per strobe");

    repeat (20) @(negedge clk);
    check(txExp.size() == 0, "R3 scoreboard empty", txExp.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule